// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when a small 8-bit processor core leaves its program to run an interrupt handler, and how long the switch and the way back take. Event sources raise sticky flags. A single level-sensitive source has no flag. A per-source enable mask and a global enable gate every source. At an instruction boundary the block accepts the highest-priority enabled request. It then steps through a fixed entry sequence: a store strobe for the 9-bit program counter, followed by a one-cycle load of the vector address. If the core was asleep, the entry sequence is longer.

On a return-from-interrupt, the block runs a fixed return sequence. This sequence gives one restore strobe and then turns the global enable back on. After that, at least one instruction of the interrupted program runs before the next request is taken. The core holds its pipeline while `busy` is high.

Vector numbering: index 0 is reserved for reset. Index 1 is the level source. Flagged source k (bit k of `evt_in`) is index k+2. A lower index wins.

Top module: `irq_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `gie`, `busy`, `push_en`, `pop_en`, `vec_load` and all `flags` are 0. The enable mask is 0.
- R2: A pulse on `evt_in[k]` sets `flags[k]`, whatever the mask holds. The flag stays set while its source or the global enable is off.
- R3: A cycle with `flag_clr_we` high clears each flag whose bit in `flag_clr_data` is 1 and leaves the others unchanged. An event on the same bit in the same cycle wins, and that flag stays 1.
- R4: A request is accepted only when all of these hold:
  - the block is idle, `gie` is 1 and the return gap is over;
  - `insn_boundary` or `sleeping` is high;
  - `reti` is low;
  - at least one enabled source is pending.

  Acceptance clears `gie`. With `gie` at 0, the block never starts an entry.
- R5: The accepted vector is the lowest pending enabled index. The level source is index 1 and uses mask bit 0. Flagged source k is index k+2 and uses mask bit k+1.
- R6: The awake entry runs as follows:
  - in the first cycle after acceptance, `busy` and `push_en` are 1;
  - `busy` stays 1 for 4 cycles in all;
  - in the next cycle `vec_load` is 1 with `vec_addr` equal to the index, and the serviced source's flag already reads 0;
  - in the cycle after that, `busy` is 0.
- R7: If `sleeping` is high at acceptance, 4 wait cycles come before the push. `push_en` rises in the 5th cycle after acceptance and `vec_load` in the 9th.
- R8: The level source has no flag. It is pending only while `level_in` is high in the accepting cycle. A pulse that ends before a boundary is not taken, and it changes no flag.
- R9: `reti` high while idle gives `pop_en` in the first following cycle. `busy` is held for 4 cycles, and `gie` is 1 in the cycle after them.
- R10: After a return, the first `insn_boundary` cannot accept a request. A later boundary can.
- R11: `gie_set` turns the global enable on and `gie_clr` turns it off. If both are high, it turns off.
- R12: `mask_we` loads `mask_wdata` into the enable mask. Only sources whose mask bit is 1 can be accepted.
- R13: Flags held while `gie` is 0 are serviced one entry at a time in index order. A lower-priority flag stays set until its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| level_in | input | 1 | Level-sensitive request (index 1) |
| evt_in | input | NUM_FLAG | Event pulses, bit k sets flag k (index k+2) |
| mask_we | input | 1 | Enable mask write strobe |
| mask_wdata | input | NUM_FLAG+1 | Mask data, bit 0 level source, bit k+1 flag k |
| flag_clr_we | input | 1 | Flag write-one-to-clear strobe |
| flag_clr_data | input | NUM_FLAG | Bits to clear |
| gie_set | input | 1 | Software turns global enable on |
| gie_clr | input | 1 | Software turns global enable off |
| insn_boundary | input | 1 | Core is between instructions |
| reti | input | 1 | Return-from-interrupt instruction executing |
| sleeping | input | 1 | Core is in sleep mode |
| gie | output | 1 | Global enable state |
| busy | output | 1 | Entry or return sequence in progress, core holds |
| push_en | output | 1 | Store the program counter on the stack |
| pop_en | output | 1 | Restore the program counter from the stack |
| vec_load | output | 1 | Load `vec_addr` into the program counter |
| vec_addr | output | PC_W | Vector address of the serviced source |
| flags | output | NUM_FLAG | Current request flags |

## Verification
The bound checker checks these properties on every cycle:
- the strobes never overlap;
- the global enable is off whenever the counter is pushed;
- no entry starts while the enable is off;
- `vec_load` lasts one cycle and carries an index in range;
- the serviced flag reads clear at vector load;
- the enable is back on whenever a return ends.

Only the bench scenarios can show the rest. These are:
- the exact cycle counts of the awake and sleeping entries and of the return;
- the priority choice across every mask and pending pattern;
- the refused first boundary after a return;
- set-over-clear on the flags;
- the disappearance of a level request that ends early.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_VECT  = 2'd2,
    ST_RET   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_FLAG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FLAG-1:0] evt,
  input  logic                clr_we,
  input  logic [NUM_FLAG-1:0] clr_data,
  input  logic [NUM_FLAG-1:0] hw_clr,
  output logic [NUM_FLAG-1:0] flags
);

  for (genvar k = 0; k < NUM_FLAG; k++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;
    logic clr_hit;

    always_comb begin
      clr_hit = (clr_we && clr_data[k]) || hw_clr[k];
      flag_en = evt[k] || clr_hit;
      flag_d  = evt[k] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign flags[k] = flag_q;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 4,
  parameter int WAKE_CYC  = 4,
  parameter int RET_CYC   = 4,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_pend,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             insn_boundary,
  input  logic             reti,
  input  logic             sleeping,
  input  logic             gie_set,
  input  logic             gie_clr,
  output logic             gie,
  output logic             busy,
  output logic             push_en,
  output logic             pop_en,
  output logic             vec_load,
  output logic [IDX_W-1:0] cur_idx,
  output logic             clr_fire
);

  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] SLEEP_LOAD = CNT_W'(ENTRY_CYC + WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] RET_LOAD   = CNT_W'(RET_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [IDX_W-1:0] idx_q;
  logic             idx_en;
  logic             gie_q, gie_d;
  logic             gap_q, gap_d;
  logic             accept;

  always_comb begin
    accept   = (st_q == ST_IDLE) && !reti && gie_q && !gap_q &&
               (insn_boundary || sleeping) && any_pend;
    st_d     = st_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    idx_en   = 1'b0;
    gie_d    = gie_q;
    gap_d    = gap_q;
    clr_fire = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (reti) begin
          st_d   = ST_RET;
          cnt_d  = RET_LOAD;
          cnt_en = 1'b1;
        end else begin
          if (insn_boundary) begin
            gap_d = 1'b0;
          end
          if (accept) begin
            st_d   = ST_ENTRY;
            cnt_d  = sleeping ? SLEEP_LOAD : ENTRY_LOAD;
            cnt_en = 1'b1;
            idx_en = 1'b1;
            gie_d  = 1'b0;
          end else if (gie_clr) begin
            gie_d = 1'b0;
          end else if (gie_set) begin
            gie_d = 1'b1;
          end
        end
      end
      ST_ENTRY: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          st_d     = ST_VECT;
          clr_fire = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_VECT: begin
        st_d = ST_IDLE;
      end
      ST_RET: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          st_d  = ST_IDLE;
          gie_d = 1'b1;
          gap_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      gie_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      gie_q <= gie_d;
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= pick_idx;
    end
  end

  assign gie      = gie_q;
  assign busy     = (st_q != ST_IDLE);
  assign push_en  = (st_q == ST_ENTRY) && (cnt_q == ENTRY_LOAD);
  assign pop_en   = (st_q == ST_RET) && (cnt_q == RET_LOAD);
  assign vec_load = (st_q == ST_VECT);
  assign cur_idx  = idx_q;

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int NUM_FLAG  = 4,
  parameter int PC_W      = 9,
  parameter int ENTRY_CYC = 4,
  parameter int WAKE_CYC  = 4,
  parameter int RET_CYC   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                level_in,
  input  logic [NUM_FLAG-1:0] evt_in,
  input  logic                mask_we,
  input  logic [NUM_FLAG:0]   mask_wdata,
  input  logic                flag_clr_we,
  input  logic [NUM_FLAG-1:0] flag_clr_data,
  input  logic                gie_set,
  input  logic                gie_clr,
  input  logic                insn_boundary,
  input  logic                reti,
  input  logic                sleeping,
  output logic                gie,
  output logic                busy,
  output logic                push_en,
  output logic                pop_en,
  output logic                vec_load,
  output logic [PC_W-1:0]     vec_addr,
  output logic [NUM_FLAG-1:0] flags
);

  localparam int NUM_SRC = NUM_FLAG + 1;
  localparam int IDX_W   = $clog2(NUM_SRC + 1);
  localparam int CNT_W   = $clog2(ENTRY_CYC + WAKE_CYC + RET_CYC + 1);

  logic                rst_sync_n;
  logic [NUM_SRC-1:0]  mask_q;
  logic [NUM_SRC-1:0]  req_vec;
  logic [NUM_FLAG-1:0] hw_clr;
  logic                any_pend;
  logic [IDX_W-1:0]    pick_idx;
  logic [IDX_W-1:0]    cur_idx;
  logic                clr_fire;

  irq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  irq_flag_bank #(.NUM_FLAG(NUM_FLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt_in),
    .clr_we   (flag_clr_we),
    .clr_data (flag_clr_data),
    .hw_clr   (hw_clr),
    .flags    (flags)
  );

  assign req_vec = mask_q & {flags, level_in};

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req (req_vec),
    .any (any_pend),
    .idx (pick_idx)
  );

  irq_seq_ctrl #(
    .ENTRY_CYC (ENTRY_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .RET_CYC   (RET_CYC),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .any_pend      (any_pend),
    .pick_idx      (pick_idx),
    .insn_boundary (insn_boundary),
    .reti          (reti),
    .sleeping      (sleeping),
    .gie_set       (gie_set),
    .gie_clr       (gie_clr),
    .gie           (gie),
    .busy          (busy),
    .push_en       (push_en),
    .pop_en        (pop_en),
    .vec_load      (vec_load),
    .cur_idx       (cur_idx),
    .clr_fire      (clr_fire)
  );

  for (genvar k = 0; k < NUM_FLAG; k++) begin : g_hwclr
    assign hw_clr[k] = clr_fire && (cur_idx == IDX_W'(k + 2));
  end

  assign vec_addr = {{(PC_W - IDX_W){1'b0}}, cur_idx};

endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int NUM_FLAG = 4,
  parameter int PC_W     = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gie,
  input logic                busy,
  input logic                push_en,
  input logic                pop_en,
  input logic                vec_load,
  input logic [PC_W-1:0]     vec_addr,
  input logic [NUM_FLAG-1:0] flags,
  input logic [NUM_FLAG-1:0] evt_in
);

  logic [NUM_FLAG-1:0] svc_oh;

  always_comb begin
    svc_oh = '0;
    for (int k = 0; k < NUM_FLAG; k++) begin
      if (vec_addr == PC_W'(k + 2)) begin
        svc_oh[k] = 1'b1;
      end
    end
  end

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop_en) && !(vec_load && (push_en || pop_en)));

  assert_gie_off_at_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !gie);

  assert_no_entry_gie_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !gie) |=> (!busy || pop_en));

  assert_vec_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (vec_addr != '0) && (vec_addr <= PC_W'(NUM_FLAG + 1)));

  assert_vec_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> (!vec_load && !busy));

  assert_flag_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> ((flags & svc_oh & ~$past(evt_in)) == '0));

  assert_gie_after_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(vec_load)) |-> gie);

endmodule

bind irq_sequencer irq_sequencer_chk #(.NUM_FLAG(NUM_FLAG), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .gie      (gie),
  .busy     (busy),
  .push_en  (push_en),
  .pop_en   (pop_en),
  .vec_load (vec_load),
  .vec_addr (vec_addr),
  .flags    (flags),
  .evt_in   (evt_in)
);

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NF         = 4;
  localparam int PCW        = 9;
  localparam int WDOG       = 200000;

  logic          clk;
  logic          rst_n;
  logic          level_in;
  logic [NF-1:0] evt_in;
  logic          mask_we;
  logic [NF:0]   mask_wdata;
  logic          flag_clr_we;
  logic [NF-1:0] flag_clr_data;
  logic          gie_set;
  logic          gie_clr;
  logic          insn_boundary;
  logic          reti;
  logic          sleeping;
  logic          gie;
  logic          busy;
  logic          push_en;
  logic          pop_en;
  logic          vec_load;
  logic [PCW-1:0] vec_addr;
  logic [NF-1:0] flags;

  int n_chk;
  int n_fail;
  bit done;

  irq_sequencer #(.NUM_FLAG(NF), .PC_W(PCW)) u0 (
    .clk (clk), .rst_n (rst_n), .level_in (level_in), .evt_in (evt_in),
    .mask_we (mask_we), .mask_wdata (mask_wdata), .flag_clr_we (flag_clr_we),
    .flag_clr_data (flag_clr_data), .gie_set (gie_set), .gie_clr (gie_clr),
    .insn_boundary (insn_boundary), .reti (reti), .sleeping (sleeping),
    .gie (gie), .busy (busy), .push_en (push_en), .pop_en (pop_en),
    .vec_load (vec_load), .vec_addr (vec_addr), .flags (flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    evt_in        = '0;
    mask_we       = 1'b0;
    mask_wdata    = '0;
    flag_clr_we   = 1'b0;
    flag_clr_data = '0;
    gie_set       = 1'b0;
    gie_clr       = 1'b0;
    insn_boundary = 1'b0;
    reti          = 1'b0;
  endtask

  task automatic nxt();
    @(negedge clk);
    idle_in();
  endtask

  // Called at the first negedge after an awake acceptance edge; ends at the
  // negedge after the vector cycle (R6).
  task automatic expect_entry(input int addr, input int exp_flags, input string tag);
    chk({tag, " R6 push first cycle"}, int'(push_en), 1);
    chk({tag, " R6 busy first cycle"}, int'(busy), 1);
    chk({tag, " R4 gie cleared"}, int'(gie), 0);
    for (int c = 0; c < 3; c++) begin
      nxt();
      chk({tag, " R6 busy hold"}, int'(busy), 1);
      chk({tag, " R6 no repeat push"}, int'(push_en), 0);
    end
    nxt();
    chk({tag, " R6 vec_load"}, int'(vec_load), 1);
    chk({tag, " R5 vec_addr"}, int'(vec_addr), addr);
    chk({tag, " R6 flag cleared"}, int'(flags), exp_flags);
    nxt();
    chk({tag, " R6 idle after vector"}, int'(busy), 0);
  endtask

  function automatic int lowest_idx(input int v);
    for (int i = 0; i < 5; i++) begin
      if (v[i]) return i + 1;
    end
    return 0;
  endfunction

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    level_in = 1'b0;
    sleeping = 1'b0;
    idle_in();
    repeat (3) @(negedge clk);
    chk("R1 gie in reset", int'(gie), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) nxt();
    chk("R1 flags after reset", int'(flags), 0);
    chk("R1 strobes after reset", int'({push_en, pop_en, vec_load}), 0);
    chk("R1 gie after reset", int'(gie), 0);
    // R1 mask is 0: a pending flag with gie on is not taken
    evt_in = 4'b0001;
    nxt(); gie_set = 1'b1;
    nxt(); insn_boundary = 1'b1;
    nxt();
    chk("R1 mask zero after reset", int'(busy), 0);

    // Sweep over all masks and pending patterns: R2, R4, R5, R6, R8, R12
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] pv;
        int pm;
        int ex;
        pv = 5'(p);
        nxt();
        flag_clr_we = 1'b1; flag_clr_data = '1;
        mask_we = 1'b1; mask_wdata = 5'(m);
        gie_clr = 1'b1; level_in = 1'b0;
        nxt();
        evt_in = pv[4:1]; level_in = pv[0];
        nxt();
        chk("R2 flag set regardless of mask", int'(flags), int'(pv[4:1]));
        chk("R4 no entry without boundary", int'(busy), 0);
        gie_set = 1'b1;
        nxt();
        chk("R11 gie set", int'(gie), 1);
        insn_boundary = 1'b1;
        nxt();
        pm = p & m;
        if (pm == 0) begin
          chk("R12 masked sources not taken", int'(busy), 0);
          chk("R2 flags held while disabled", int'(flags), int'(pv[4:1]));
          chk("R4 gie unchanged", int'(gie), 1);
        end else begin
          ex = lowest_idx(pm);
          expect_entry(ex, (ex >= 2) ? (int'(pv[4:1]) & ~(1 << (ex - 2))) : int'(pv[4:1]),
                       "R5 sweep");
        end
      end
    end
    level_in = 1'b0;

    // R3: write-one-to-clear, set wins over clear
    nxt(); flag_clr_we = 1'b1; flag_clr_data = '1; gie_clr = 1'b1;
    nxt(); evt_in = 4'b1111;
    nxt(); flag_clr_we = 1'b1; flag_clr_data = 4'b0101;
    nxt();
    chk("R3 selective clear", int'(flags), 4'b1010);
    evt_in = 4'b0001; flag_clr_we = 1'b1; flag_clr_data = 4'b0011;
    nxt();
    chk("R3 event beats clear", int'(flags), 4'b1001);

    // R11: clear beats set
    gie_set = 1'b1; gie_clr = 1'b1;
    nxt();
    chk("R11 clear wins", int'(gie), 0);

    // R7: sleeping entry
    nxt(); flag_clr_we = 1'b1; flag_clr_data = '1; mask_we = 1'b1; mask_wdata = '1; gie_set = 1'b1;
    nxt(); evt_in = 4'b0100; sleeping = 1'b1;
    nxt();
    chk("R7 not before flag", int'(busy), 0);
    nxt();
    for (int c = 1; c <= 8; c++) begin
      chk("R7 busy during wake entry", int'(busy), 1);
      chk("R7 push position", int'(push_en), (c == 5) ? 1 : 0);
      nxt();
    end
    chk("R7 vec_load after wake", int'(vec_load), 1);
    chk("R7 vec_addr", int'(vec_addr), 4);
    sleeping = 1'b0;
    nxt();
    chk("R7 idle after vector", int'(busy), 0);

    // R4 multi-cycle wait, R13 held order, R9 return, R10 gap
    nxt(); flag_clr_we = 1'b1; flag_clr_data = '1; gie_set = 1'b1;
    nxt(); evt_in = 4'b1001;
    for (int c = 0; c < 3; c++) begin
      nxt();
      chk("R4 wait for boundary", int'(busy), 0);
    end
    insn_boundary = 1'b1;
    nxt();
    expect_entry(2, 4'b1000, "R13 first");
    insn_boundary = 1'b1;
    nxt();
    chk("R13 held while gie off", int'(busy), 0);
    chk("R13 lower flag kept", int'(flags), 4'b1000);
    reti = 1'b1; insn_boundary = 1'b1;
    nxt();
    chk("R9 pop first cycle", int'(pop_en), 1);
    chk("R9 busy", int'(busy), 1);
    chk("R9 gie still off", int'(gie), 0);
    for (int c = 0; c < 3; c++) begin
      nxt();
      chk("R9 busy hold", int'(busy), 1);
      chk("R9 single pop", int'(pop_en), 0);
    end
    nxt();
    chk("R9 return done", int'(busy), 0);
    chk("R9 gie restored", int'(gie), 1);
    insn_boundary = 1'b1;
    nxt();
    chk("R10 first boundary refused", int'(busy), 0);
    insn_boundary = 1'b1;
    nxt();
    expect_entry(5, 4'b0000, "R10 second boundary");

    // R8: level pulse that ends before a boundary
    nxt(); mask_we = 1'b1; mask_wdata = 5'b00001; gie_set = 1'b1; level_in = 1'b1;
    nxt(); level_in = 1'b0; insn_boundary = 1'b1;
    nxt();
    chk("R8 dropped level not taken", int'(busy), 0);
    chk("R8 no flag from level", int'(flags), 0);
    level_in = 1'b1; insn_boundary = 1'b1;
    nxt();
    expect_entry(1, 0, "R8 level taken");
    level_in = 1'b0;

    // R1: reset in the middle of an entry
    nxt(); mask_we = 1'b1; mask_wdata = '1; gie_set = 1'b1; evt_in = 4'b0010;
    nxt(); insn_boundary = 1'b1;
    nxt();
    chk("R1 entry started", int'(busy), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset busy", int'(busy), 0);
    chk("R1 async reset flags", int'(flags), 0);
    nxt(); rst_n = 1'b1;
    repeat (3) nxt();
    chk("R1 gie after second reset", int'(gie), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule